// File: doc/BRIEF.md
# Daisy-Chain SPI Node Controller

This block is one node in a chain of SPI peripherals. Every node shares a single active-low chip select and a single serial clock. Each node's serial output drives the serial input of the next node, and the master listens only to the output of the last node. One command frame gives the master the command (which every node except the last passes on), followed by a fixed 16-bit check word from every node, in node order, with no gaps between the words.

The node runs on a fast local clock. It passes chip select, SCLK and the serial input through synchronisers, detects the SCLK edges, and counts the rising edges since chip select fell. Three windows are decoded from that count:
- a local select that clocks the node's own response out of a shift register;
- an own-word window whose start moves by one word plus one bit for each position in the chain;
- for the last node only, a window that blanks the command echo.

Whenever the own-word window is closed and no blanking applies, the upstream bit passes through with one SCLK period of latency. The response always leaves the shift register at the same count, whatever the node's position. A delay line of (position − 1) × (word + 1) bits then moves it to its slot, so the first node has no delay line.

The interface is bit-serial and the master sets the pace through SCLK. There is no valid/ready handshake and no back-pressure. A node cannot stall the chain, and every bit has a fixed slot. The position, the chain length, the command and word sizes and the check word are parameters. Rising edges are numbered k = 1, 2, … from the fall of chip select. "The output after rise k" is the value the node drives after the SCLK falling edge that follows rise k. The downstream node or the master samples that value at rise k+1.

Top module: `daisy_chain_node`

## Requirements
- R1: While chip select is high, sdo is 0. Raising chip select in the middle of a frame clears the counter, the response register and the delay line, so the next frame behaves like the first one after reset. Before the first rise of a frame, sdo is 0.
- R2: sdi is taken only on SCLK rising edges. sdo changes only after SCLK falling edges and holds its value through the following high phase.
- R3: Outside its own-word window, a node that is not last drives, after rise k, the sdi value it took at rise k. The master shifts the command MSB first, command bit C−k at rise k for k = 1..C, and holds sdi at 0 afterwards. The command therefore appears at the output of node P after rises P..C+P−1.
- R4: The last node (POS = NODES) drives 0 after every rise k ≤ C + NODES − 1, so the command is never echoed back to the master.
- R5: Node P drives its CHECK_WORD MSB first after rises C+1+(P−1)(W+1) through C+(P−1)(W+1)+W. Upstream data is replaced in that window.
- R6: On the last node's output, node 1's word starts after rise C+NODES. The words of nodes 2..NODES follow back to back, W bits each.
- R7: The returned words do not depend on the command bits shifted in.
- R8: The node works correctly when each SCLK phase lasts at least 6 local clock cycles. This is far above a 3.4 MHz SCLK for a local clock of a few hundred MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Shared chip select, active low |
| sclk_i | input | 1 | Shared serial clock from the master |
| sdi_i | input | 1 | Serial input from the upstream node or master |
| sdo_o | output | 1 | Serial output to the downstream node or master |

## Verification
The assertions check on every cycle that the edge counter, the response register, the delay line and the output staging only move on the SCLK edge that owns them. sdo stays frozen between falling edges and the count steps by exactly one per rising edge. Only the bench can show the slot arithmetic. That covers:
- the per-position start of each own word;
- the one-period forwarding latency that adds up along the chain;
- the command blanking at the last node;
- the back-to-back order of the four words as the master sees them.

The bench also shows that an aborted frame leaves nothing behind and that two SCLK rates give identical streams.

// File: rtl/dchain_pkg.sv
`timescale 1ns/1ps
package dchain_pkg;

  // Source feeding the output staging bit at a rising edge.
  typedef enum logic [1:0] {
    SRC_UPSTREAM = 2'd0,
    SRC_OWN      = 2'd1,
    SRC_BLANK    = 2'd2
  } sdo_src_e;

  // First rise at which the local responder shifts its word out.
  function automatic int resp_start(input int cmd_bits);
    return cmd_bits + 1;
  endfunction

  // Extra rises a node's own word is held back: one word plus one bit per
  // upstream node (the extra bit is each node's forwarding latency).
  function automatic int node_delay(input int pos, input int word_bits);
    return (pos - 1) * (word_bits + 1);
  endfunction

  // Last rise on which the final node suppresses the command echo.
  function automatic int blank_end(input int cmd_bits, input int nodes);
    return cmd_bits + nodes - 1;
  endfunction

  // Rises in a complete frame, with a small tail margin.
  function automatic int frame_rises(input int cmd_bits, input int word_bits,
                                     input int nodes);
    return cmd_bits + nodes * (word_bits + 1) + 2;
  endfunction

endpackage

// File: rtl/dchain_edge_sync.sv
`timescale 1ns/1ps
module dchain_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic cs_act_o,
  output logic rise_o,
  output logic fall_o,
  output logic sdi_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] cs_pipe;
  logic [SYNC_STAGES-1:0] sclk_pipe;
  logic [SYNC_STAGES-1:0] sdi_pipe;
  logic                   sclk_last;

  // sdi travels through the same number of stages as sclk, so the bit seen
  // at a detected edge is the one present when that edge arrived.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe   <= '1;
      sclk_pipe <= '0;
      sdi_pipe  <= '0;
      sclk_last <= 1'b0;
    end else begin
      cs_pipe   <= SYNC_STAGES'({cs_pipe, cs_n_i});
      sclk_pipe <= SYNC_STAGES'({sclk_pipe, sclk_i});
      sdi_pipe  <= SYNC_STAGES'({sdi_pipe, sdi_i});
      sclk_last <= sclk_pipe[TOP];
    end
  end

  assign cs_act_o = ~cs_pipe[TOP];
  assign rise_o   = cs_act_o &  sclk_pipe[TOP] & ~sclk_last;
  assign fall_o   = cs_act_o & ~sclk_pipe[TOP] &  sclk_last;
  assign sdi_o    = sdi_pipe[TOP];

endmodule

// File: rtl/dchain_frame_seq.sv
`timescale 1ns/1ps
module dchain_frame_seq
  import dchain_pkg::*;
#(
  parameter int POS       = 1,
  parameter int NODES     = 4,
  parameter int CMD_BITS  = 16,
  parameter int WORD_BITS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_act_i,
  input  logic     rise_i,
  output logic     lcs_o,
  output sdo_src_e src_o
);

  localparam int FRAME   = frame_rises(CMD_BITS, WORD_BITS, NODES);
  localparam int CNT_W   = $clog2(FRAME + 1);
  localparam int RESP_T0 = resp_start(CMD_BITS);
  localparam int OWN_T0  = RESP_T0 + node_delay(POS, WORD_BITS);
  localparam int BLK_END = blank_end(CMD_BITS, NODES);
  localparam bit IS_LAST = (POS == NODES);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W:0]   K_RESP_LO = (CNT_W+1)'(RESP_T0);
  localparam logic [CNT_W:0]   K_RESP_HI = (CNT_W+1)'(RESP_T0 + WORD_BITS);
  localparam logic [CNT_W:0]   K_OWN_LO  = (CNT_W+1)'(OWN_T0);
  localparam logic [CNT_W:0]   K_OWN_HI  = (CNT_W+1)'(OWN_T0 + WORD_BITS);
  localparam logic [CNT_W:0]   K_BLANK   = (CNT_W+1)'(BLK_END);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   knext;
  logic             own_win;
  logic             blank_win;

  // Number of rising edges seen since chip select fell (saturating).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!cs_act_i)                cnt <= '0;
    else if (rise_i && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
  end

  // Index of the rise being handled right now.
  assign knext = {1'b0, cnt} + (CNT_W+1)'(1);

  assign lcs_o   = (knext >= K_RESP_LO) && (knext < K_RESP_HI);
  assign own_win = (knext >= K_OWN_LO)  && (knext < K_OWN_HI);

  generate
    if (IS_LAST) begin : g_blank
      assign blank_win = (knext <= K_BLANK);
    end else begin : g_noblank
      assign blank_win = 1'b0;
    end
  endgenerate

  always_comb begin
    if (own_win)        src_o = SRC_OWN;
    else if (blank_win) src_o = SRC_BLANK;
    else                src_o = SRC_UPSTREAM;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act_i && !rise_i) |=> $stable(cnt)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act_i && rise_i && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_W'(1))); // R3

endmodule

// File: rtl/dchain_responder.sv
`timescale 1ns/1ps
module dchain_responder #(
  parameter int                   WORD_BITS  = 16,
  parameter logic [WORD_BITS-1:0] CHECK_WORD = 16'h2199
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act_i,
  input  logic rise_i,
  input  logic lcs_i,
  output logic resp_bit_o
);

  logic [WORD_BITS-1:0] sr;

  // Reloaded whenever the frame is idle; shifts MSB first under local select.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sr <= CHECK_WORD;
    else if (!cs_act_i)       sr <= CHECK_WORD;
    else if (rise_i && lcs_i) sr <= WORD_BITS'({sr, 1'b0});
  end

  assign resp_bit_o = lcs_i & sr[WORD_BITS-1];

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act_i && !(rise_i && lcs_i)) |=> $stable(sr)); // R5

endmodule

// File: rtl/dchain_delay.sv
`timescale 1ns/1ps
module dchain_delay #(
  parameter int DEPTH = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act_i,
  input  logic rise_i,
  input  logic bit_i,
  output logic bit_o
);

  logic [DEPTH-1:0] dl;

  // One stage per SCLK rise. The tail is read before the shift, so a bit
  // written at rise k is read at rise k+DEPTH.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dl <= '0;
    else if (!cs_act_i) dl <= '0;
    else if (rise_i)    dl <= DEPTH'({dl, bit_i});
  end

  assign bit_o = dl[DEPTH-1];

  AST_DL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act_i && !rise_i) |=> $stable(dl)); // R5

endmodule

// File: rtl/dchain_out_stage.sv
`timescale 1ns/1ps
module dchain_out_stage
  import dchain_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_act_i,
  input  logic     rise_i,
  input  logic     fall_i,
  input  sdo_src_e src_i,
  input  logic     own_bit_i,
  input  logic     sdi_i,
  output logic     sdo_o
);

  logic stage;
  logic sdo_q;

  // Choose the bit on the rise, present it on the following fall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= 1'b0;
      sdo_q <= 1'b0;
    end else if (!cs_act_i) begin
      stage <= 1'b0;
      sdo_q <= 1'b0;
    end else begin
      if (rise_i) begin
        unique case (src_i)
          SRC_OWN:   stage <= own_bit_i;
          SRC_BLANK: stage <= 1'b0;
          default:   stage <= sdi_i;
        endcase
      end
      if (fall_i) sdo_q <= stage;
    end
  end

  assign sdo_o = sdo_q;

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act_i && !fall_i) |=> $stable(sdo_o)); // R2

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act_i && !rise_i) |=> $stable(stage)); // R2

endmodule

// File: rtl/daisy_chain_node.sv
`timescale 1ns/1ps
module daisy_chain_node
  import dchain_pkg::*;
#(
  parameter int                   POS         = 1,
  parameter int                   NODES       = 4,
  parameter int                   CMD_BITS    = 16,
  parameter int                   WORD_BITS   = 16,
  parameter int                   SYNC_STAGES = 2,
  parameter logic [WORD_BITS-1:0] CHECK_WORD  = 16'h2199
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o
);

  localparam int DLY = node_delay(POS, WORD_BITS);

  logic     cs_act;
  logic     rise;
  logic     fall;
  logic     sdi_s;
  logic     lcs;
  sdo_src_e src;
  logic     resp_bit;
  logic     own_bit;

  dchain_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_i   (cs_n_i),
    .sclk_i   (sclk_i),
    .sdi_i    (sdi_i),
    .cs_act_o (cs_act),
    .rise_o   (rise),
    .fall_o   (fall),
    .sdi_o    (sdi_s)
  );

  dchain_frame_seq #(
    .POS       (POS),
    .NODES     (NODES),
    .CMD_BITS  (CMD_BITS),
    .WORD_BITS (WORD_BITS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act_i (cs_act),
    .rise_i   (rise),
    .lcs_o    (lcs),
    .src_o    (src)
  );

  dchain_responder #(
    .WORD_BITS  (WORD_BITS),
    .CHECK_WORD (CHECK_WORD)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act_i   (cs_act),
    .rise_i     (rise),
    .lcs_i      (lcs),
    .resp_bit_o (resp_bit)
  );

  generate
    if (DLY == 0) begin : g_first
      assign own_bit = resp_bit;
    end else begin : g_delayed
      dchain_delay #(.DEPTH(DLY)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act_i (cs_act),
        .rise_i   (rise),
        .bit_i    (resp_bit),
        .bit_o    (own_bit)
      );
    end
  endgenerate

  dchain_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act_i  (cs_act),
    .rise_i    (rise),
    .fall_i    (fall),
    .src_i     (src),
    .own_bit_i (own_bit),
    .sdi_i     (sdi_s),
    .sdo_o     (sdo_o)
  );

endmodule

// File: tb/sim_daisy_chain_node.sv
`timescale 1ns/1ps
module sim_daisy_chain_node;

  localparam int NODES = 4;
  localparam int C     = 16;
  localparam int W     = 16;
  localparam int KMAX  = C + NODES * (W + 1) + 2;
  localparam logic [15:0] WORDS [NODES] = '{16'h2199, 16'h3FCB, 16'h23D5, 16'h3003};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cs_n, sclk, mosi;
  logic [NODES:0] link;
  assign link[0] = mosi;

  for (genvar g = 0; g < NODES; g++) begin : gen_node
    daisy_chain_node #(
      .POS        (g + 1),
      .NODES      (NODES),
      .CMD_BITS   (C),
      .WORD_BITS  (W),
      .CHECK_WORD (WORDS[g])
    ) u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n_i (cs_n),
      .sclk_i (sclk),
      .sdi_i  (link[g]),
      .sdo_o  (link[g+1])
    );
  end

  int   vectors = 0;
  int   fails   = 0;
  bit   done    = 1'b0;
  logic exp_o [0:NODES][0:KMAX];
  logic cap   [0:KMAX];

  task automatic check_bit(input string tag, input int p, input int k,
                           input logic act, input logic expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s node %0d rise %0d: got %b expected %b", tag, p, k, act, expv);
    end
  endtask

  // Expected output of every node after every rise, from the slot rules.
  task automatic build_exp(input logic [15:0] cmd);
    for (int j = 0; j <= KMAX; j++) exp_o[0][j] = (j < C) ? cmd[C-1-j] : 1'b0;
    for (int p = 1; p <= NODES; p++) begin
      exp_o[p][0] = 1'b0;
      for (int k = 1; k <= KMAX; k++) begin
        int s;
        s = C + 1 + (p - 1) * (W + 1);
        if (k >= s && k < s + W)                exp_o[p][k] = WORDS[p-1][W-1-(k-s)];
        else if (p == NODES && k <= C + NODES - 1) exp_o[p][k] = 1'b0;
        else                                     exp_o[p][k] = exp_o[p-1][k-1];
      end
    end
  endtask

  function automatic string slot_tag(input int p, input int k);
    int s;
    s = C + 1 + (p - 1) * (W + 1);
    if (k >= s && k < s + W) return "R5";
    if (p == NODES && k <= C + NODES - 1) return "R4";
    return "R3";
  endfunction

  task automatic idle_check(input string tag);
    for (int p = 1; p <= NODES; p++) check_bit(tag, p, 0, link[p], 1'b0);
  endtask

  task automatic run_frame(input logic [15:0] cmd, input int h, input int stop_at,
                           input string stream_tag);
    int last;
    build_exp(cmd);
    last = (stop_at > 0) ? stop_at : KMAX;
    @(negedge clk); cs_n = 1'b0; mosi = 1'b0;
    repeat (6) @(negedge clk);
    idle_check("R1");
    for (int k = 1; k <= last; k++) begin
      mosi = (k <= C) ? cmd[C-k] : 1'b0;
      @(negedge clk); sclk = 1'b1;
      repeat (h / 2) @(negedge clk);
      for (int p = 1; p <= NODES; p++) check_bit("R2", p, k, link[p], exp_o[p][k-1]);
      repeat (h - h / 2) @(negedge clk);
      sclk = 1'b0;
      repeat (h - 1) @(negedge clk);
      for (int p = 1; p <= NODES; p++) check_bit(slot_tag(p, k), p, k, link[p], exp_o[p][k]);
      cap[k] = link[NODES];
    end
    if (stop_at == 0) begin
      for (int i = 0; i < NODES; i++) begin
        logic [15:0] got;
        for (int b = 0; b < W; b++) got[W-1-b] = cap[C + NODES + i * W + b];
        vectors++;
        if (got !== WORDS[i]) begin
          fails++;
          $display("FAIL %s master word %0d: got %h expected %h", stream_tag, i + 1, got, WORDS[i]);
        end
      end
    end
    @(negedge clk); cs_n = 1'b1; mosi = 1'b0;
    repeat (6) @(negedge clk);
    idle_check("R1");
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    repeat (5) @(negedge clk);
    idle_check("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check("R1");
    run_frame(16'hA226, 10, 0, "R6");
    run_frame(16'h0000, 10, 0, "R7");
    run_frame(16'hFFFF, 10, 0, "R7");
    run_frame(16'h5A3C, 10, 30, "R1");  // aborted mid-frame
    run_frame(16'h5A3C, 10, 0, "R1");   // fresh frame after abort
    run_frame(16'hA226, 6, 0, "R8");
    run_frame(16'hC3E1, 6, 0, "R8");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule